// File: doc/BRIEF.md
# Serial Bit Clock Divider

This block generates a serial bit clock for a shift engine. It runs entirely in the system clock domain. A divider input tick comes either from a divide-by-two of the system clock or from the rising edges of an external clock, which is resynchronised first. An 8-bit divide value sets how many ticks the clock spends in its high phase and in its low phase. Even values give a high phase one tick longer than the low phase. Odd values, and zero, give equal phases.

Software writes the divide value, the source select and the polarity into a shadow register through a one-cycle write strobe. The divider copies the shadow into its working configuration only when a new high phase begins, so a phase that is already running always finishes at its old length. Downstream logic receives the clock level and two single-cycle strobes that mark the rising and falling edges of that level. When the polarity bit is set, both strobes follow the inverted clock.

Top module: `sbclk_gen`

## Requirements
- R1: With `cfg_src` = 1, one divider tick S lasts two system clock cycles.
- R2: With `cfg_src` = 0, `ext_clk` passes through a two-flop synchronizer, and each of its rising edges gives one single-cycle tick, so S equals one `ext_clk` period. Two ticks are never adjacent.
- R3: For an even nonzero divide value G, the internal high phase lasts (G/2 + 1)·S and the low phase lasts (G/2)·S.
- R4: For an odd divide value G, the high and low phases each last ((G+1)/2)·S.
- R5: A divide value of 0 gives a high phase of 1·S and a low phase of 1·S.
- R6: With `cfg_pol` = 1, `bclk_o` is the inverse of the internal phase. `rise_stb_o` and `fall_stb_o` then mark the edges of the inverted level, so the measured high time of `bclk_o` equals the internal low phase.
- R7: `rise_stb_o` is high for exactly the one cycle in which `bclk_o` has just gone from 0 to 1. `fall_stb_o` is high for exactly the one cycle in which it has just gone from 1 to 0. The two are never high together.
- R8: A value written with `cfg_we` = 1 takes effect only when the next internal high phase begins. A phase that is already in progress completes with its old length.
- R9: While `rst_n` = 0, `bclk_o`, `rise_stb_o` and `fall_stb_o` are 0. After reset the working configuration is G = 0, `cfg_src` = 1 and `cfg_pol` = 0.
- R10: Two rising strobes are never less than two system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External divider source clock, asynchronous |
| cfg_we | input | 1 | Write strobe for the shadow configuration |
| cfg_div | input | 8 | Divide value G |
| cfg_src | input | 1 | Source select: 1 = system clock / 2, 0 = external clock |
| cfg_pol | input | 1 | 1 = inverted bit clock |
| bclk_o | output | 1 | Bit clock level |
| rise_stb_o | output | 1 | One-cycle strobe on a rising edge of `bclk_o` |
| fall_stb_o | output | 1 | One-cycle strobe on a falling edge of `bclk_o` |

## Verification
A corrupt phase counter or length function changes the number of cycles between a rising strobe and the next falling strobe. The wrong count shows within one bit period, and the bench measures both the high and the low interval for each divide value. If the working configuration is copied at the wrong moment, the phase during which the write lands comes out at the new length instead of the old one, and this shows in the very next edge spacing. A lost polarity or a misaligned strobe makes a strobe disagree with the `bclk_o` level in the same cycle, which the bench detects at the first edge.

// File: rtl/sbclk_pkg.sv
package sbclk_pkg;

  // Number of ticks the internal phase spends high for divide value g.
  function automatic logic [15:0] hi_len_f(input logic [15:0] g);
    if (g == 16'd0)   return 16'd1;
    else if (g[0])    return (g + 16'd1) >> 1;
    else              return (g >> 1) + 16'd1;
  endfunction

  // Number of ticks the internal phase spends low for divide value g.
  function automatic logic [15:0] lo_len_f(input logic [15:0] g);
    if (g == 16'd0)   return 16'd1;
    else if (g[0])    return (g + 16'd1) >> 1;
    else              return g >> 1;
  endfunction

endpackage

// File: rtl/sbclk_tick_src.sv
module sbclk_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic sel_sys,
  output logic tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   half_q;
  logic                   ext_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
      half_q     <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      ext_prev_q <= sync_q[SYNC_STAGES-1];
      half_q     <= ~half_q;
    end
  end

  assign ext_edge = sync_q[SYNC_STAGES-1] & ~ext_prev_q;
  assign tick     = sel_sys ? half_q : ext_edge;

  AST_EXT_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);                                        // R2
  AST_SYS_TICK_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_sys) |=> (!tick || !sel_sys));                     // R1

endmodule

// File: rtl/sbclk_phase.sv
module sbclk_phase
  import sbclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] sh_div,
  input  logic             sh_src,
  input  logic             sh_pol,
  output logic             act_src,
  output logic             bclk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);
  localparam int CNT_W = DIV_W;

  logic             hi_q, act_pol_q, act_src_q, out_q, rise_q, fall_q;
  logic [DIV_W-1:0] act_div_q;
  logic [CNT_W-1:0] cnt_q;

  logic             phase_end, start_hi, start_lo;
  logic             nxt_hi, nxt_pol, nxt_src, nxt_out;
  logic [DIV_W-1:0] nxt_div;
  logic [CNT_W-1:0] nxt_cnt;

  assign phase_end = tick && (cnt_q == '0);
  assign start_hi  = phase_end && !hi_q;
  assign start_lo  = phase_end && hi_q;

  always_comb begin
    nxt_hi  = phase_end ? !hi_q : hi_q;
    nxt_pol = start_hi ? sh_pol : act_pol_q;
    nxt_src = start_hi ? sh_src : act_src_q;
    nxt_div = start_hi ? sh_div : act_div_q;
    if (start_hi)
      nxt_cnt = CNT_W'(hi_len_f(16'(sh_div)) - 16'd1);
    else if (start_lo)
      nxt_cnt = CNT_W'(lo_len_f(16'(act_div_q)) - 16'd1);
    else if (tick)
      nxt_cnt = cnt_q - 1'b1;
    else
      nxt_cnt = cnt_q;
    nxt_out = nxt_hi ^ nxt_pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= 1'b0;
      cnt_q     <= '0;
      act_div_q <= '0;
      act_src_q <= 1'b1;
      act_pol_q <= 1'b0;
      out_q     <= 1'b0;
      rise_q    <= 1'b0;
      fall_q    <= 1'b0;
    end else begin
      hi_q      <= nxt_hi;
      cnt_q     <= nxt_cnt;
      act_div_q <= nxt_div;
      act_src_q <= nxt_src;
      act_pol_q <= nxt_pol;
      out_q     <= nxt_out;
      rise_q    <= nxt_out & ~out_q;
      fall_q    <= ~nxt_out & out_q;
    end
  end

  assign act_src    = act_src_q;
  assign bclk_o     = out_q;
  assign rise_stb_o = rise_q;
  assign fall_stb_o = fall_q;

  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(hi_q));                                       // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    16'(cnt_q) < hi_len_f(16'(act_div_q)));                         // R4
  AST_CFG_HELD_MID_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_hi) |=> $stable(act_div_q) && $stable(act_pol_q));      // R8
  AST_RISE_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |-> (bclk_o && !$past(bclk_o)));                     // R7
  AST_FALL_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb_o |-> (!bclk_o && $past(bclk_o)));                     // R7
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb_o && fall_stb_o));                                   // R7
  AST_MIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |=> !rise_stb_o);                                    // R10
  AST_POL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_o == (hi_q ^ act_pol_q));                                  // R6

endmodule

// File: rtl/sbclk_gen.sv
module sbclk_gen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_src,
  input  logic             cfg_pol,
  output logic             bclk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);
  logic [DIV_W-1:0] sh_div_q;
  logic             sh_src_q, sh_pol_q;
  logic             act_src, tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div_q <= '0;
      sh_src_q <= 1'b1;
      sh_pol_q <= 1'b0;
    end else if (cfg_we) begin
      sh_div_q <= cfg_div;
      sh_src_q <= cfg_src;
      sh_pol_q <= cfg_pol;
    end
  end

  sbclk_tick_src #(.SYNC_STAGES(SYNC_STAGES)) tick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ext_clk),
    .sel_sys (act_src),
    .tick    (tick)
  );

  sbclk_phase #(.DIV_W(DIV_W)) phase_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .sh_div     (sh_div_q),
    .sh_src     (sh_src_q),
    .sh_pol     (sh_pol_q),
    .act_src    (act_src),
    .bclk_o     (bclk_o),
    .rise_stb_o (rise_stb_o),
    .fall_stb_o (fall_stb_o)
  );

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> (!bclk_o && !rise_stb_o && !fall_stb_o));            // R9

endmodule

// File: tb/sbclk_gen_tb.sv
module sbclk_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 9;

  logic       clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
  logic       cfg_we = 1'b0, cfg_src = 1'b1, cfg_pol = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic       bclk_o, rise_stb_o, fall_stb_o;

  int errors = 0, checks = 0, cyc = 0;

  // {div, src, pol, expected bclk high cycles, expected bclk low cycles}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'd3,   8'd1, 8'd0, 16'd4,   16'd4},   // R4 odd, R1
    {8'd4,   8'd1, 8'd0, 16'd6,   16'd4},   // R3 even
    {8'd2,   8'd1, 8'd0, 16'd4,   16'd2},   // R3 smallest even
    {8'd0,   8'd1, 8'd0, 16'd2,   16'd2},   // R5 zero
    {8'd5,   8'd1, 8'd1, 16'd6,   16'd6},   // R6 odd inverted
    {8'd6,   8'd1, 8'd1, 16'd6,   16'd8},   // R6 even inverted
    {8'd4,   8'd0, 8'd0, 16'd18,  16'd12},  // R2 external, period 6 clocks
    {8'd255, 8'd1, 8'd0, 16'd256, 16'd256}, // R4 largest odd
    {8'd254, 8'd1, 8'd0, 16'd256, 16'd254}  // R3 largest even
  };

  sbclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cfg_we(cfg_we),
    .cfg_div(cfg_div), .cfg_src(cfg_src), .cfg_pol(cfg_pol),
    .bclk_o(bclk_o), .rise_stb_o(rise_stb_o), .fall_stb_o(fall_stb_o)
  );

  always #(CLK_P/2) clk = ~clk;
  initial begin
    #2;
    forever #(3*CLK_P) ext_clk = ~ext_clk;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic write_cfg(input logic [7:0] d, input logic s, input logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = d; cfg_src = s; cfg_pol = p;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!rise_stb_o) @(negedge clk);
  endtask

  task automatic count_hi(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!fall_stb_o);
  endtask

  task automatic count_lo(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!rise_stb_o);
  endtask

  initial begin
    int hi, lo;
    // R9 reset state
    repeat (4) @(negedge clk);
    check("R9 reset bclk", bclk_o, 0);
    check("R9 reset rise", rise_stb_o, 0);
    check("R9 reset fall", fall_stb_o, 0);
    rst_n = 1'b1;

    // R9 default configuration is divide 0 on system clock / 2
    wait_rise();
    check("R7 level at rise", bclk_o, 1);
    count_hi(hi);
    check("R7 level at fall", bclk_o, 0);
    count_lo(lo);
    check("R9 default hi", hi, 2);
    check("R9 default lo", lo, 2);

    for (int i = 0; i < NVEC; i++) begin
      write_cfg(VEC[i][55:48], VEC[i][40], VEC[i][32]);
      repeat (3) wait_rise();
      wait_rise();
      count_hi(hi);
      count_lo(lo);
      check($sformatf("R3/R4/R5/R6 vec%0d hi", i), hi, int'(VEC[i][31:16]));
      check($sformatf("R3/R4/R5/R6 vec%0d lo", i), lo, int'(VEC[i][15:0]));
    end

    // R8: a write landing mid high phase must not shorten it
    write_cfg(8'd8, 1'b1, 1'b0);
    repeat (3) wait_rise();
    wait_rise();
    hi = 0;
    do begin
      @(negedge clk); hi++;
      if (hi == 1) check("R7 rise one cycle", rise_stb_o, 0);
      if (hi == 2) begin cfg_we = 1'b1; cfg_div = 8'd0; end
      if (hi == 3) cfg_we = 1'b0;
    end while (!fall_stb_o);
    count_lo(lo);
    check("R8 old hi kept", hi, 10);
    check("R8 old lo kept", lo, 8);
    count_hi(hi);
    check("R8 new hi applied", hi, 2);
    check("R10 fall one cycle", fall_stb_o, 1);
    @(negedge clk);
    check("R7 fall one cycle", fall_stb_o, 0);

    // R9: reset during operation forces the idle level at once
    write_cfg(8'd9, 1'b1, 1'b0);
    repeat (2) wait_rise();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async reset bclk", bclk_o, 0);
    @(negedge clk);
    check("R9 reset strobes", rise_stb_o | fall_stb_o, 0);
    rst_n = 1'b1;
    wait_rise();
    count_hi(hi);
    check("R9 config cleared by reset", hi, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule